// File: doc/BRIEF.md
# Memory Controller Reset Sequencer

This block walks the soft resets of one memory channel's controller and PHY through a fixed three-step release. A single-cycle start pulse, together with a one-bit channel select, launches the sequence. The block then issues three reset control words on a write strobe, one for each step. Each word carries the reset levels in its lower half and per-bit write enables in its upper half. Only the enables of the chosen channel are set, so the receiving register leaves the other channel alone.

The three steps come in a fixed order. First both resets are held. Next the PHY is let go while the controller stays in reset. Last both are released. Each step lasts a fixed number of microseconds. The block measures this time against a free-running 32-bit system counter that the surrounding chip supplies. The tick rate in MHz and the wait length in microseconds are parameters. When the wait after the third word expires, the block pulses done for one cycle and is ready for the next start. It has no data stream, so every pin is a plain control or status signal.

Top module: `mem_rst_sequencer`

## Requirements
- R1: After reset, rst_word is all zero and rst_wr, busy and done are low.
- R2: A start pulse while idle produces the first write strobe on the next cycle, and busy is high from that cycle on.
- R3: Word encoding for channel c (0 or 1): the controller reset level is bit 8+4c and the PHY reset level is bit 9+4c. Their write enables are bits 24+4c and 25+4c, and every other bit is zero. A level of 1 means reset asserted.
- R4: The three words come in this order: both levels 1, then controller 1 with PHY 0, then both 0.
- R5: The wait target is WAIT_US×TICK_MHZ ticks. A step ends on the first cycle in which the ticks elapsed since that step's word was issued exceed the target. With the counter advancing once per clock, successive strobes are target+1 cycles apart.
- R6: Elapsed ticks are correct when the 32-bit counter wraps from all ones to zero during a wait, so the spacing stays target+1.
- R7: A start pulse while the sequence runs is ignored. The channel, the words and the timing stay the same, and no extra strobe follows the sequence.
- R8: done is a one-cycle pulse, target+1 cycles after the third strobe, and busy is low in that cycle.
- R9: Each sequence produces exactly three rst_wr pulses, each one cycle wide.
- R10: The enable and level bits of the channel that is not selected stay zero in every word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| ch_sel | input | 1 | Channel whose resets are stepped |
| sys_cnt | input | 32 | Free-running system tick counter |
| rst_word | output | 32 | Write-masked reset control word |
| rst_wr | output | 1 | One-cycle strobe marking a new rst_word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the last wait expires |

## Verification
On every cycle the checker confirms several properties. A strobe and the done pulse are each a single cycle wide. An idle start always leads to a strobe. A start during a run never ends the run early. Every word carries exactly one channel's pair of enables and nothing in its low byte, and the first word of a run holds both resets. The exact wait lengths, the wrap of the tick counter, the full word order for each channel and the absence of a late extra sequence can only be shown by the bench's scenarios. These scenarios drive the counter and count the cycles between strobes.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int CTL_BIT0  = 8;
  localparam int PHY_BIT0  = 9;
  localparam int CH_STRIDE = 4;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_HOLD_ALL = 2'd1,
    ST_PHY_FREE = 2'd2,
    ST_ALL_FREE = 2'd3
  } step_e;
endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int CNT_W    = 32,
  parameter int TICK_MHZ = 24,
  parameter int WAIT_US  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             expired
);
  localparam logic [CNT_W-1:0] TARGET  = CNT_W'(WAIT_US * TICK_MHZ);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   base_q <= '0;
    else if (arm) base_q <= cnt_in;
  end

  // The counter may have wrapped between the base sample and now.
  always_comb begin
    if (cnt_in >= base_q) delta = cnt_in - base_q;
    else                  delta = (CNT_TOP - base_q) + cnt_in + CNT_W'(1);
  end

  assign expired = (delta > TARGET);
endmodule

// File: rtl/rstseq_encoder.sv
module rstseq_encoder #(
  parameter int WORD_W = 32,
  parameter int NUM_CH = 2
) (
  input  logic              ch,
  input  logic              ctl_on,
  input  logic              phy_on,
  output logic [WORD_W-1:0] word
);
  import rstseq_pkg::*;
  localparam int HALF = WORD_W / 2;

  logic [NUM_CH-1:0] hit;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      assign hit[g] = (ch == 1'(g));
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int g = 0; g < NUM_CH; g++) begin
      word[CTL_BIT0 + CH_STRIDE*g]        = hit[g] & ctl_on;
      word[PHY_BIT0 + CH_STRIDE*g]        = hit[g] & phy_on;
      word[CTL_BIT0 + CH_STRIDE*g + HALF] = hit[g];
      word[PHY_BIT0 + CH_STRIDE*g + HALF] = hit[g];
    end
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  ch_sel,
  input  logic  expired,
  output logic  load,
  output logic  finish,
  output logic  ch_eff,
  output step_e next_step,
  output logic  running
);
  step_e state_q;
  logic  ch_q;

  always_comb begin
    next_step = state_q;
    load      = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        next_step = ST_HOLD_ALL;
        load      = 1'b1;
      end
      ST_HOLD_ALL: if (expired) begin
        next_step = ST_PHY_FREE;
        load      = 1'b1;
      end
      ST_PHY_FREE: if (expired) begin
        next_step = ST_ALL_FREE;
        load      = 1'b1;
      end
      ST_ALL_FREE: if (expired) begin
        next_step = ST_IDLE;
        finish    = 1'b1;
      end
      default: next_step = ST_IDLE;
    endcase
  end

  assign ch_eff  = (state_q == ST_IDLE) ? ch_sel : ch_q;
  assign running = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= 1'b0;
    end else begin
      state_q <= next_step;
      if (state_q == ST_IDLE && start) ch_q <= ch_sel;
    end
  end
endmodule

// File: rtl/mem_rst_sequencer.sv
module mem_rst_sequencer #(
  parameter int TICK_MHZ = 24,
  parameter int WAIT_US  = 10,
  parameter int CNT_W    = 32,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ch_sel,
  input  logic [CNT_W-1:0]  sys_cnt,
  output logic [WORD_W-1:0] rst_word,
  output logic              rst_wr,
  output logic              busy,
  output logic              done
);
  import rstseq_pkg::*;

  logic  load, finish, ch_eff, expired, running;
  step_e next_step;
  logic  ctl_on, phy_on;
  logic [WORD_W-1:0] word_d;

  rstseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ch_sel(ch_sel),
    .expired(expired), .load(load), .finish(finish), .ch_eff(ch_eff),
    .next_step(next_step), .running(running)
  );

  rstseq_timer #(.CNT_W(CNT_W), .TICK_MHZ(TICK_MHZ), .WAIT_US(WAIT_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(load), .cnt_in(sys_cnt), .expired(expired)
  );

  assign ctl_on = (next_step == ST_HOLD_ALL) || (next_step == ST_PHY_FREE);
  assign phy_on = (next_step == ST_HOLD_ALL);

  rstseq_encoder #(.WORD_W(WORD_W), .NUM_CH(2)) u_enc (
    .ch(ch_eff), .ctl_on(ctl_on), .phy_on(phy_on), .word(word_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_word <= '0;
      rst_wr   <= 1'b0;
      done     <= 1'b0;
    end else begin
      rst_wr <= load;
      done   <= finish;
      if (load) rst_word <= word_d;
    end
  end

  assign busy = running;
endmodule

// File: rtl/mem_rst_sequencer_chk.sv
module mem_rst_sequencer_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] rst_word,
  input logic              rst_wr,
  input logic              busy,
  input logic              done
);
  localparam int HALF = WORD_W / 2;

  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (rst_wr && busy));

  a_r9_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> !rst_wr);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |-> ($countones(rst_word[WORD_W-1:HALF]) == 2 && rst_word[7:0] == 8'h00));

  a_r4_first_holds_both: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wr && !$past(busy)) |-> ($countones(rst_word[HALF-1:0]) == 2));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind mem_rst_sequencer mem_rst_sequencer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rst_word(rst_word),
  .rst_wr(rst_wr), .busy(busy), .done(done)
);

// File: tb/mem_rst_sequencer_tb.sv
module mem_rst_sequencer_tb;
  localparam int TICK_MHZ = 24;
  localparam int WAIT_US  = 10;
  localparam int GAP      = WAIT_US * TICK_MHZ + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ch_sel = 1'b0;
  logic [31:0] sys_cnt = '0;
  logic        cnt_load = 1'b0;
  logic [31:0] cnt_val = '0;
  logic [31:0] rst_word;
  logic        rst_wr, busy, done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  always @(posedge clk) sys_cnt <= cnt_load ? cnt_val : sys_cnt + 32'd1;

  mem_rst_sequencer #(.TICK_MHZ(TICK_MHZ), .WAIT_US(WAIT_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ch_sel(ch_sel), .sys_cnt(sys_cnt),
    .rst_word(rst_word), .rst_wr(rst_wr), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int c, input int ctl, input int phy);
    exp_word = (32'(ctl) << (8 + 4*c)) | (32'(phy) << (9 + 4*c)) | (32'h3 << (24 + 4*c));
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 word", rst_word, 32'h0);
    chk("R1 wr", {31'h0, rst_wr}, 32'h0);
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);
  endtask

  // One full sequence; optional restart attempt mid-run with the other channel.
  task automatic t_run(input int c, input logic [31:0] cnt0, input bit poke, input string tag);
    int          nwr = 0;
    int          wcyc[3];
    logic [31:0] wd[3];
    int          dcyc = -1;
    int          cyc = 1;
    logic        busy_at_done = 1'b1;
    @(negedge clk);
    cnt_load = 1'b1; cnt_val = cnt0;
    @(negedge clk);
    cnt_load = 1'b0;
    ch_sel = c[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 4 * GAP) begin
      if (rst_wr) begin
        if (nwr < 3) begin wcyc[nwr] = cyc; wd[nwr] = rst_word; end
        nwr++;
      end
      if (done) begin dcyc = cyc; busy_at_done = busy; break; end
      if (poke && cyc == GAP + 60) begin start = 1'b1; ch_sel = ~c[0]; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({tag, " R9 strobe count"}, 32'(nwr), 32'd3);
    if (nwr == 3) begin
      chk({tag, " R2 first strobe cycle"}, 32'(wcyc[0]), 32'd1);
      chk({tag, " R4 R3 word1"}, wd[0], exp_word(c, 1, 1));
      chk({tag, " R4 R10 word2"}, wd[1], exp_word(c, 1, 0));
      chk({tag, " R4 R10 word3"}, wd[2], exp_word(c, 0, 0));
      chk({tag, " R5 R6 gap1"}, 32'(wcyc[1] - wcyc[0]), 32'(GAP));
      chk({tag, " R5 R6 gap2"}, 32'(wcyc[2] - wcyc[1]), 32'(GAP));
      chk({tag, " R8 done delay"}, 32'(dcyc - wcyc[2]), 32'(GAP));
    end
    chk({tag, " R8 busy low at done"}, {31'h0, busy_at_done}, 32'h0);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, {31'h0, done}, 32'h0);
    if (poke) begin
      int extra = 0;
      for (int k = 0; k < GAP + 10; k++) begin
        if (rst_wr || busy) extra++;
        @(negedge clk);
      end
      chk({tag, " R7 no late sequence"}, 32'(extra), 32'd0);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_run(0, 32'h0000_1000, 1'b0, "ch0");
        t_run(1, 32'h0000_5000, 1'b0, "ch1");
        t_run(0, 32'hFFFF_FF80, 1'b0, "wrap0");
        t_run(1, 32'hFFFF_FE40, 1'b0, "wrap1");
        t_run(0, 32'h0000_0000, 1'b1, "restart");
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule